// File: doc/BRIEF.md
# Entropy-Driven Split Search Neuron

This block trains a single self-organizing neuron. Labelled two-class samples, each made of two unsigned fields, are loaded into local storage through a simple write port. After a start pulse the engine works through seven fixed integer transformations in turn. For each one it transforms every sample into an intermediate memory. It then tries each transformed value as a split threshold and scores the resulting binary partition with a fixed-point conditional-entropy measure.

A running best is kept across all functions and thresholds. When the last function is finished, the engine divides the best score by the class entropy term to form the information deficiency. It then raises a one-clock done pulse with the chosen function index, threshold and deficiency. Those outputs stay put until the next start. Logarithms come from a 16-entry fractional table rather than floating point.

Top module: `ent_split_neuron`

## Requirements
- R1: After reset, done_o is 0 and thr_o, func_o and def_o are all 0.
- R2: A write with wr_en_i high stores wr_a_i, wr_b_i and wr_cls_i at wr_addr_i, and a later write to the same address replaces them. A run uses samples 0 to n-1, with n taken from n_i in the cycle that start_i is seen (1 <= n <= DEPTH). Later changes to n_i do not affect that run.
- R3: Function codes on func_o are 0 a, 1 -a, 2 a+b, 3 a-b, 4 floor((a+b)/2), 5 max(a,b) and 6 min(a,b). Each result is a signed value DW+2 bits wide.
- R4: For each function, the candidate thresholds are the transformed values of samples 0..n-1, taken in sample order. A sample lies on the high side of candidate t when its transformed value is >= t, using a signed compare.
- R5: For a count c > 0, let m be its highest set bit and k the low 4 bits of (16*c >> m). Then L(c) = 256*m + round(256*log2(1+k/16)) and nl(c) = c*L(c), with nl(0) = 0. The score of a split is S = nl(h) - nl(h0) - nl(h1) + nl(l) - nl(l0) - nl(l1). Here h and l are the high-side and low-side sample counts, and the suffixes 0 and 1 count the samples of class 0 and class 1 on each side.
- R6: The reported function and threshold are those of the minimum S over all functions and candidates. Because only a strictly smaller score replaces the held best, ties go to the lowest function code and then to the earliest candidate.
- R7: Let E = nl(n) - nl(n0) - nl(n1) be the class entropy term. def_o is floor(256*S_best/E), an unsigned value with 8 fractional bits that never exceeds 256. When E = 0 (all samples share one class), def_o is 0.
- R8: done_o is high for exactly one clock when a run completes.
- R9: After completion, thr_o, func_o and def_o hold their values until the next start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Sample write strobe |
| wr_addr_i | input | AW | Sample write address |
| wr_a_i | input | DW | First sample field |
| wr_b_i | input | DW | Second sample field |
| wr_cls_i | input | 1 | Sample class label |
| n_i | input | CW | Number of samples to train on |
| start_i | input | 1 | Start a training run |
| done_o | output | 1 | One-clock completion pulse |
| thr_o | output | DW+2 | Chosen threshold, signed |
| func_o | output | 3 | Chosen function code |
| def_o | output | 9 | Information deficiency, Q1.8 |

## Verification
The assertions take for granted that no samples are written while a run is in progress, that n_i lies between 1 and DEPTH when start_i is raised, and that start_i is raised only while the engine is idle. The bench loads all samples before each start, keeps n within bounds, and raises start only after the previous done pulse. It scrambles n_i after each start to show that the run uses the captured count. The random data mixes full-range fields with narrow ones, so that many scores tie and the ordering rule decides the result.

// File: rtl/esn_pkg.sv
package esn_pkg;
  localparam int NFUNC = 7;
  localparam int FW    = 3;

  typedef enum logic [FW-1:0] {
    FN_IDENT = 3'd0, FN_NEG = 3'd1, FN_SUM = 3'd2, FN_DIFF = 3'd3,
    FN_HALF  = 3'd4, FN_MAX = 3'd5, FN_MIN = 3'd6
  } fn_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_XFORM, ST_SCAN, ST_SCORE, ST_CMP, ST_DIVGO, ST_DIVW
  } st_e;
endpackage

// File: rtl/esn_xform.sv
module esn_xform import esn_pkg::*; #(
  parameter int DW = 8,
  localparam int YW = DW + 2
) (
  input  logic [DW-1:0]        a_i,
  input  logic [DW-1:0]        b_i,
  input  logic [FW-1:0]        fn_i,
  output logic signed [YW-1:0] y_o
);
  logic signed [YW-1:0] sa, sb;
  logic signed [YW-1:0] res [NFUNC];

  assign sa = $signed({2'b00, a_i});
  assign sb = $signed({2'b00, b_i});

  for (genvar g = 0; g < NFUNC; g++) begin : g_fn
    if (g == int'(FN_IDENT))     begin : g_id   assign res[g] = sa;                   end
    else if (g == int'(FN_NEG))  begin : g_neg  assign res[g] = -sa;                  end
    else if (g == int'(FN_SUM))  begin : g_sum  assign res[g] = sa + sb;              end
    else if (g == int'(FN_DIFF)) begin : g_dif  assign res[g] = sa - sb;              end
    else if (g == int'(FN_HALF)) begin : g_half assign res[g] = (sa + sb) >>> 1;      end
    else if (g == int'(FN_MAX))  begin : g_max  assign res[g] = (sa > sb) ? sa : sb;  end
    else                         begin : g_min  assign res[g] = (sa < sb) ? sa : sb;  end
  end

  always_comb begin
    y_o = '0;
    for (int k = 0; k < NFUNC; k++)
      if (fn_i == FW'(k)) y_o = res[k];
  end
endmodule

// File: rtl/esn_nlogn.sv
module esn_nlogn #(
  parameter int CW = 11,
  localparam int MW = $clog2(CW),
  localparam int LW = MW + 8,
  localparam int OW = CW + LW
) (
  input  logic [CW-1:0] cnt_i,
  output logic [OW-1:0] val_o
);
  logic [MW-1:0]   msb;
  logic [CW+3:0]   mant;
  logic [7:0]      frac;
  logic [LW-1:0]   lg;

  // round(256*log2(1+k/16))
  function automatic logic [7:0] frac_lut(input logic [3:0] k);
    case (k)
      4'd0:  return 8'd0;    4'd1:  return 8'd22;
      4'd2:  return 8'd44;   4'd3:  return 8'd63;
      4'd4:  return 8'd82;   4'd5:  return 8'd100;
      4'd6:  return 8'd118;  4'd7:  return 8'd134;
      4'd8:  return 8'd150;  4'd9:  return 8'd165;
      4'd10: return 8'd179;  4'd11: return 8'd193;
      4'd12: return 8'd207;  4'd13: return 8'd220;
      4'd14: return 8'd232;  default: return 8'd244;
    endcase
  endfunction

  always_comb begin
    msb = '0;
    for (int k = 0; k < CW; k++)
      if (cnt_i[k]) msb = MW'(k);
  end

  assign mant  = {cnt_i, 4'b0000} >> msb;
  assign frac  = frac_lut(mant[3:0]);
  assign lg    = {msb, frac};
  assign val_o = OW'(cnt_i) * OW'(lg);
endmodule

// File: rtl/esn_div.sv
module esn_div #(
  parameter int NW = 32,
  parameter int MW = 24,
  localparam int CNTW = $clog2(NW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [MW-1:0] den_i,
  output logic          done_o,
  output logic [NW-1:0] quo_o
);
  logic [NW-1:0]   q_q;
  logic [MW-1:0]   rem_q, den_q;
  logic [CNTW-1:0] cnt_q;
  logic            run_q, done_q;
  logic [MW:0]     trial, diff;
  logic            ge;

  assign trial = {rem_q, q_q[NW-1]};
  assign ge    = trial >= {1'b0, den_q};
  assign diff  = trial - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0; rem_q <= '0; den_q <= '0; cnt_q <= '0;
      run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        q_q <= num_i; rem_q <= '0; den_q <= den_i;
        cnt_q <= CNTW'(NW); run_q <= 1'b1;
      end else if (run_q) begin
        q_q   <= {q_q[NW-2:0], ge};
        rem_q <= ge ? diff[MW-1:0] : trial[MW-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNTW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = q_q;

  // R7: partial remainder stays below a non-zero divisor
  a_r7_rem_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && den_q != '0) |-> (rem_q < den_q));
endmodule

// File: rtl/ent_split_neuron.sv
module ent_split_neuron import esn_pkg::*; #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int YW  = DW + 2,
  localparam int LW  = $clog2(CW) + 8,
  localparam int OW  = CW + LW,
  localparam int SW  = OW + 1,
  localparam int NW  = SW + 8,
  localparam int DFW = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_a_i,
  input  logic [DW-1:0]        wr_b_i,
  input  logic                 wr_cls_i,
  input  logic [CW-1:0]        n_i,
  input  logic                 start_i,
  output logic                 done_o,
  output logic signed [YW-1:0] thr_o,
  output logic [FW-1:0]        func_o,
  output logic [DFW-1:0]       def_o
);
  logic [DW-1:0]        mem_a [DEPTH];
  logic [DW-1:0]        mem_b [DEPTH];
  logic [DEPTH-1:0]     cls_q;
  logic signed [YW-1:0] y_q   [DEPTH];

  st_e                  st_q;
  logic [FW-1:0]        fn_q, bfn_q;
  logic [AW-1:0]        idx_q, cand_q;
  logic [CW-1:0]        n_q, n1_q, hi_q, hi1_q, lo_w, lo1_w, term_w;
  logic [2:0]           step_q;
  logic [SW-1:0]        acc_q, best_q, e_q;
  logic signed [YW-1:0] thr_q, y_w;
  logic [DFW-1:0]       def_q;
  logic                 done_q, ge_w, idx_last, cand_last, div_done;
  logic [OW-1:0]        nl_w;
  logic [NW-1:0]        quo_w;

  esn_xform #(.DW(DW)) u_xform (
    .a_i(mem_a[idx_q]), .b_i(mem_b[idx_q]), .fn_i(fn_q), .y_o(y_w)
  );

  always_comb begin
    case (step_q)
      3'd0:    term_w = hi_q;
      3'd1:    term_w = hi_q - hi1_q;
      3'd2:    term_w = hi1_q;
      3'd3:    term_w = lo_w;
      3'd4:    term_w = lo_w - lo1_w;
      default: term_w = lo1_w;
    endcase
  end

  esn_nlogn #(.CW(CW)) u_nlogn (.cnt_i(term_w), .val_o(nl_w));

  esn_div #(.NW(NW), .MW(SW)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(st_q == ST_DIVGO),
    .num_i({best_q, 8'h00}), .den_i(e_q), .done_o(div_done), .quo_o(quo_w)
  );

  assign lo_w      = n_q - hi_q;
  assign lo1_w     = n1_q - hi1_q;
  assign ge_w      = y_q[idx_q] >= y_q[cand_q];
  assign idx_last  = CW'(idx_q)  == n_q - CW'(1);
  assign cand_last = CW'(cand_q) == n_q - CW'(1);

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem_a[wr_addr_i] <= wr_a_i;
      mem_b[wr_addr_i] <= wr_b_i;
      cls_q[wr_addr_i] <= wr_cls_i;
    end
    if (st_q == ST_XFORM) y_q[idx_q] <= y_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; fn_q <= '0; bfn_q <= '0; idx_q <= '0; cand_q <= '0;
      n_q <= '0; n1_q <= '0; hi_q <= '0; hi1_q <= '0; step_q <= '0;
      acc_q <= '0; best_q <= '1; e_q <= '0; thr_q <= '0; def_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          n_q <= n_i; fn_q <= '0; idx_q <= '0; n1_q <= '0;
          best_q <= '1; st_q <= ST_XFORM;
        end
        ST_XFORM: begin
          if (fn_q == '0 && cls_q[idx_q]) n1_q <= n1_q + CW'(1);
          if (idx_last) begin
            idx_q <= '0; cand_q <= '0; hi_q <= '0; hi1_q <= '0;
            st_q <= ST_SCAN;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_SCAN: begin
          hi_q  <= hi_q + CW'(ge_w);
          hi1_q <= hi1_q + CW'(ge_w & cls_q[idx_q]);
          if (idx_last) begin
            idx_q <= '0; step_q <= '0; acc_q <= '0; st_q <= ST_SCORE;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_SCORE: begin
          acc_q  <= (step_q == 3'd0 || step_q == 3'd3) ? acc_q + SW'(nl_w)
                                                       : acc_q - SW'(nl_w);
          step_q <= step_q + 3'd1;
          if (step_q == 3'd5) st_q <= ST_CMP;
        end
        ST_CMP: begin
          // all samples on the high side: score equals the class term
          if (hi_q == n_q) e_q <= acc_q;
          if (acc_q < best_q) begin
            best_q <= acc_q; thr_q <= y_q[cand_q]; bfn_q <= fn_q;
          end
          hi_q <= '0; hi1_q <= '0;
          if (cand_last) begin
            cand_q <= '0;
            if (fn_q == FW'(NFUNC - 1)) st_q <= ST_DIVGO;
            else begin fn_q <= fn_q + 1'b1; st_q <= ST_XFORM; end
          end else begin
            cand_q <= cand_q + 1'b1; st_q <= ST_SCAN;
          end
        end
        ST_DIVGO: st_q <= ST_DIVW;
        ST_DIVW: if (div_done) begin
          def_q  <= (e_q == '0) ? '0 : quo_w[DFW-1:0];
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign thr_o  = thr_q;
  assign func_o = bfn_q;
  assign def_o  = def_q;

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !start_i) |=>
      ($stable(thr_o) && $stable(func_o) && $stable(def_o)));

  a_r6_best_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> (best_q <= $past(best_q)));

  a_r7_def_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DIVW && div_done && e_q != '0) |-> (quo_w <= NW'(256)));

  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SCORE) |-> (hi_q <= n_q && hi1_q <= hi_q && hi1_q <= n1_q));

  a_r3_func_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_o <= FW'(NFUNC - 1));
endmodule

// File: tb/test_ent_split_neuron.sv
`timescale 1ns/1ps
module test_ent_split_neuron;
  localparam int DEPTH = 1024;
  localparam int AW = 10;
  localparam int CW = 11;
  localparam int DW = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, wr_cls_i = 1'b0, start_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_a_i = '0, wr_b_i = '0;
  logic [CW-1:0] n_i = '0;
  logic done_o;
  logic signed [DW+1:0] thr_o;
  logic [2:0] func_o;
  logic [8:0] def_o;

  int tests = 0, fails = 0;
  int ma [DEPTH], mb [DEPTH], ml [DEPTH];
  int ys [DEPTH];
  int frac_t [16];
  int e_thr, e_fn, e_def;

  always #2.5 clk = ~clk;

  ent_split_neuron i_ent_split_neuron (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_a_i(wr_a_i), .wr_b_i(wr_b_i), .wr_cls_i(wr_cls_i), .n_i(n_i),
    .start_i(start_i), .done_o(done_o), .thr_o(thr_o), .func_o(func_o),
    .def_o(def_o)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nl(int c);
    int m = 0;
    if (c == 0) return 0;
    for (int k = 0; k < 31; k++) if ((c >> k) & 1) m = k;
    return c * (256 * m + frac_t[((c << 4) >> m) & 15]);
  endfunction

  function automatic int xf(int f, int a, int b);
    case (f)
      0: return a;
      1: return -a;
      2: return a + b;
      3: return a - b;
      4: return (a + b) / 2;
      5: return (a > b) ? a : b;
      default: return (a < b) ? a : b;
    endcase
  endfunction

  task automatic model(int n);
    int best = 32'h7fffffff, n1 = 0, e;
    for (int i = 0; i < n; i++) n1 += ml[i];
    for (int f = 0; f < 7; f++) begin
      for (int i = 0; i < n; i++) ys[i] = xf(f, ma[i], mb[i]);
      for (int j = 0; j < n; j++) begin
        int h = 0, h1 = 0, l, l1, s;
        for (int i = 0; i < n; i++)
          if (ys[i] >= ys[j]) begin h++; h1 += ml[i]; end
        l = n - h; l1 = n1 - h1;
        s = nl(h) - nl(h - h1) - nl(h1) + nl(l) - nl(l - l1) - nl(l1);
        if (s < best) begin best = s; e_thr = ys[j]; e_fn = f; end
      end
    end
    e = nl(n) - nl(n - n1) - nl(n1);
    e_def = (e == 0) ? 0 : int'((longint'(best) * 256) / e);
  endtask

  task automatic wr(int addr, int a, int b, int c);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = AW'(addr);
    wr_a_i = DW'(a); wr_b_i = DW'(b); wr_cls_i = c[0];
    ma[addr] = a; mb[addr] = b; ml[addr] = c;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic run(int n, string tag);
    int cnt = 0, h_thr, h_fn, h_def;
    @(negedge clk);
    n_i = CW'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; n_i = CW'($urandom);  // R2: must not affect the run
    while (!done_o && cnt < 100000) begin @(negedge clk); cnt++; end
    if (!done_o) begin
      tests++; fails++;
      $display("FAIL R8 %s: no done, actual 0 expected 1", tag);
      return;
    end
    model(n);
    check({"R6 thr ", tag}, int'(thr_o), e_thr);
    check({"R6 func ", tag}, int'(func_o), e_fn);
    check({"R7 def ", tag}, int'(def_o), e_def);
    h_thr = int'(thr_o); h_fn = int'(func_o); h_def = int'(def_o);
    @(negedge clk);
    check({"R8 done low ", tag}, int'(done_o), 0);
    repeat (4) @(negedge clk);
    check({"R9 hold ", tag}, int'(thr_o) + 1000 * int'(func_o) + 10000 * int'(def_o),
          h_thr + 1000 * h_fn + 10000 * h_def);
  endtask

  initial begin
    #(5.0 * 195000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 16; k++)
      frac_t[k] = $rtoi(256.0 * $ln(1.0 + k / 16.0) / $ln(2.0) + 0.5);

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 done", int'(done_o), 0);
    check("R1 thr", int'(thr_o), 0);
    check("R1 func", int'(func_o), 0);
    check("R1 def", int'(def_o), 0);

    // R7: one class only -> E = 0, every score 0, first candidate wins
    for (int i = 0; i < 8; i++) wr(i, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), 0);
    run(8, "one-class");
    check("R7 one-class def zero", int'(def_o), 0);
    check("R6 one-class first cand", int'(thr_o), ma[0]);

    // R3/R4: only the difference function separates the classes
    for (int i = 0; i < 16; i++) wr(i, 100 + i, (i % 2 == 0) ? 95 + i : 105 + i, (i % 2 == 0) ? 1 : 0);
    run(16, "diff-split");
    check("R3 diff func code", int'(func_o), 3);
    check("R4 diff threshold", int'(thr_o), 5);
    check("R7 diff perfect def", int'(def_o), 0);

    // single sample corner
    wr(0, 77, 3, 1);
    run(1, "n1");
    check("R4 n1 threshold", int'(thr_o), 77);

    // R2: overwrite then run; random runs, wide and narrow ranges
    for (int r = 0; r < 10; r++) begin
      int n = int'($urandom_range(2, 24));
      int span = (r % 2 == 0) ? 255 : 7;
      for (int i = 0; i < n; i++)
        wr(i, int'($urandom_range(0, span)), int'($urandom_range(0, span)), int'($urandom_range(0, 1)));
      wr(0, int'($urandom_range(0, span)), int'($urandom_range(0, span)), int'($urandom_range(0, 1)));
      run(n, $sformatf("R2 R5 rand%0d", r));
    end

    for (int i = 0; i < 48; i++)
      wr(i, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), int'($urandom_range(0, 1)));
    run(48, "large");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule